// File: doc/BRIEF.md
# SPI attenuator command decoder

This block is the target side of a 24-bit SPI link that sets the step attenuators of an RF front end. Each frame is classified by its two most significant bits. One kind is a plain access to 16-bit control registers. Two kinds are gain commands for the receive or transmit path, which look up a pair of 6-bit attenuator settings in a built-in gain table. The fourth kind loads a value straight into one or both local-oscillator attenuators.

While a frame is being shifted in, the block shifts a reply out on MISO. For attenuator frames the reply carries the current settings of the attenuator pair that the frame addresses. For register reads it carries the register contents. SCLK, chip select and MOSI are brought into the system clock domain through a synchronizer, and the block finds the SCLK edges there. A command takes effect only when chip select is released after exactly 24 bits.

A register selects the high-band or low-band table separately for each direction. A scratch register is provided so that the SPI path can be checked by reading back what was written.

Top module: `spi_atten_ctrl`

## Requirements
- R1: A frame is received MSB first, one bit on each rising SCLK edge while chip select (active low) is asserted. The frame is acted on when chip select deasserts, and only if exactly 24 bits were received. Frames of any other length change nothing.
- R2: While reset is high, all four gain-path attenuator outputs are 6'h3F, both LO attenuator outputs are 30, the scratch and band registers are zero, and MISO is low.
- R3: Bits 23:22 give the frame kind: 0 is a register access, 1 is a receive gain command, 2 is a transmit gain command, and 3 is an LO attenuator command.
- R4: In a register access, bits 23:17 are the address, bit 16 set means read, and bits 15:0 are the write data. Address 0x05 is a scratch register that reads back the last value written. Address 0x06 is the band register: bit 0 selects high band for receive and bit 1 selects high band for transmit. Its other bits read zero. All other addresses read zero and ignore writes.
- R5: In a gain command, bits 21:16 are the index i, and T = 60 - i. Receive low band gives first = ceil(T/2) and second = floor(T/2). Receive high band gives first = floor(T/2) and second = ceil(T/2). Transmit low band gives first = T and second = 0. Transmit high band gives first = 0 and second = T. The band is taken from the band register for the command's direction.
- R6: In a gain command, bit 13 enables the update of the first attenuator and bit 6 enables the update of the second. An attenuator whose enable is clear keeps its value.
- R7: A gain command with an index above 60 changes no output.
- R8: In an LO command, bits 21:16 are the attenuation in dB. Bit 13 loads it into the receive LO attenuator and bit 6 loads it into the transmit LO attenuator. A value above 30 is ignored, so the LO outputs never exceed 30.
- R9: MISO changes after falling SCLK edges and gives the reply MSB first. For a register read the reply is the register data in bits 15:0, with all other bits zero. For every other frame, bits 12:7 and 5:0 hold the first and second settings of the pair the frame addresses, and all other bits are zero. Kind 1 and register writes address the receive pair, kind 2 addresses the transmit pair, and kind 3 addresses the LO pair, with each value zero-extended to 6 bits.
- R10: The attenuator outputs change only in the cycle after a complete 24-bit frame is applied.
- R11: MISO is held low while chip select is deasserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial reply to the controller |
| rx_att_a | output | 6 | Receive path first attenuator setting |
| rx_att_b | output | 6 | Receive path second attenuator setting |
| tx_att_a | output | 6 | Transmit path first attenuator setting |
| tx_att_b | output | 6 | Transmit path second attenuator setting |
| rx_lo_att | output | 5 | Receive LO attenuator setting in dB |
| tx_lo_att | output | 5 | Transmit LO attenuator setting in dB |

## Verification
The hardest case to reach is the reply to a register read. Its data bits must start leaving on MISO at bit 15, when only the address and read flag of that same frame have arrived. The bench therefore writes the scratch and band registers and then reads them back inside single frames, comparing all 24 returned bits. Frames of 23 and 25 bits are sent after the state has been loaded with non-reset values, so that a discarded frame shows up at the outputs as no change. The band register is switched between gain commands so that all four table variants are used.

// File: rtl/spi_att_pkg.sv
package spi_att_pkg;

    localparam int          FRAME_W  = 24;
    localparam int          ATT_W    = 6;
    localparam int          LO_W     = 5;
    localparam logic [5:0]  IDX_MAX  = 6'd60;
    localparam logic [5:0]  LO_MAX   = 6'd30;
    localparam logic [6:0]  ADDR_SCR = 7'h05;
    localparam logic [6:0]  ADDR_BND = 7'h06;

    typedef enum logic [1:0] {
        K_REG = 2'd0,
        K_RXG = 2'd1,
        K_TXG = 2'd2,
        K_LO  = 2'd3
    } frame_kind_e;

    typedef struct packed {
        logic [ATT_W-1:0] first;
        logic [ATT_W-1:0] second;
    } att_pair_t;

    // Gain table: total attenuation T = 60 - index, split per direction/band
    function automatic att_pair_t gain_lookup(input logic is_tx,
                                              input logic hi_band,
                                              input logic [5:0] idx);
        logic [5:0] total;
        logic [5:0] dn;
        logic [5:0] up;
        att_pair_t  p;
        total = IDX_MAX - idx;
        dn    = total >> 1;
        up    = total - dn;
        case ({is_tx, hi_band})
            2'b00:   p = '{first: up,    second: dn};
            2'b01:   p = '{first: dn,    second: up};
            2'b10:   p = '{first: total, second: 6'd0};
            default: p = '{first: 6'd0,  second: total};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import spi_att_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk_i,
    input  logic               csn_i,
    input  logic               mosi_i,
    input  logic [FRAME_W-1:0] reply_i,
    output logic               miso_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               done_o,
    output logic               cs_idle_o
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
    localparam logic [CNT_W-1:0] TOP_POS  = CNT_W'(FRAME_W - 1);

    // {sclk, csn, mosi} through a synchronizer chain
    logic [2:0] sync_q [SYNC_STAGES];

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 3'b010;
                else     sync_q[g] <= {sclk_i, csn_i, mosi_i};
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 3'b010;
                else     sync_q[g] <= sync_q[g-1];
            end
        end
    end

    logic sclk_s, cs_s, mosi_s;
    assign {sclk_s, cs_s, mosi_s} = sync_q[SYNC_STAGES-1];

    logic             sclk_q, cs_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pos;
    logic             sclk_rise, sclk_fall;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign pos       = TOP_POS - cnt_q;
    assign cs_idle_o = cs_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            cs_q    <= 1'b1;
            cnt_q   <= '0;
            frame_o <= '0;
            miso_o  <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            cs_q   <= cs_s;
            done_o <= 1'b0;
            if (cs_s) begin
                miso_o <= 1'b0;
                if (!cs_q) done_o <= (cnt_q == CNT_FULL);
            end else if (cs_q) begin
                cnt_q   <= '0;
                frame_o <= '0;
                miso_o  <= 1'b0;
            end else begin
                if (sclk_rise) begin
                    if (cnt_q < CNT_FULL) frame_o[pos] <= mosi_s;
                    if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
                end
                if (sclk_fall)
                    miso_o <= (cnt_q < CNT_FULL) ? reply_i[pos] : 1'b0;
            end
        end
    end

endmodule

// File: rtl/att_cmd_exec.sv
module att_cmd_exec
    import spi_att_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               apply_i,
    input  logic [FRAME_W-1:0] frame_i,
    output att_pair_t          rx_pair_o,
    output att_pair_t          tx_pair_o,
    output logic [LO_W-1:0]    rx_lo_o,
    output logic [LO_W-1:0]    tx_lo_o,
    output logic [15:0]        scratch_o,
    output logic [1:0]         band_o
);
    frame_kind_e kind;
    logic [6:0]  addr;
    logic [5:0]  field;
    logic        en_a, en_b, is_tx;
    att_pair_t   look;

    assign kind  = frame_kind_e'(frame_i[23:22]);
    assign addr  = frame_i[23:17];
    assign field = frame_i[21:16];
    assign en_a  = frame_i[13];
    assign en_b  = frame_i[6];
    assign is_tx = (kind == K_TXG);
    assign look  = gain_lookup(is_tx, band_o[is_tx], field);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_pair_o <= '{first: '1, second: '1};
            tx_pair_o <= '{first: '1, second: '1};
            rx_lo_o   <= LO_W'(LO_MAX);
            tx_lo_o   <= LO_W'(LO_MAX);
            scratch_o <= '0;
            band_o    <= '0;
        end else if (apply_i) begin
            case (kind)
                K_REG: begin
                    if (!frame_i[16]) begin
                        if (addr == ADDR_SCR) scratch_o <= frame_i[15:0];
                        else if (addr == ADDR_BND) band_o <= frame_i[1:0];
                    end
                end
                K_RXG, K_TXG: begin
                    if (field <= IDX_MAX) begin
                        if (is_tx) begin
                            if (en_a) tx_pair_o.first  <= look.first;
                            if (en_b) tx_pair_o.second <= look.second;
                        end else begin
                            if (en_a) rx_pair_o.first  <= look.first;
                            if (en_b) rx_pair_o.second <= look.second;
                        end
                    end
                end
                default: begin
                    if (field <= LO_MAX) begin
                        if (en_a) rx_lo_o <= field[LO_W-1:0];
                        if (en_b) tx_lo_o <= field[LO_W-1:0];
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/spi_atten_ctrl.sv
module spi_atten_ctrl
    import spi_att_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            spi_sclk,
    input  logic            spi_csn,
    input  logic            spi_mosi,
    output logic            spi_miso,
    output logic [ATT_W-1:0] rx_att_a,
    output logic [ATT_W-1:0] rx_att_b,
    output logic [ATT_W-1:0] tx_att_a,
    output logic [ATT_W-1:0] tx_att_b,
    output logic [LO_W-1:0]  rx_lo_att,
    output logic [LO_W-1:0]  tx_lo_att
);
    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] reply;
    logic               frame_done;
    logic               cs_idle;
    att_pair_t          rx_pair, tx_pair;
    logic [15:0]        scratch;
    logic [1:0]         band;
    logic [15:0]        rd_data;
    frame_kind_e        kind;
    logic               reg_rd;

    spi_frame_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .sclk_i    (spi_sclk),
        .csn_i     (spi_csn),
        .mosi_i    (spi_mosi),
        .reply_i   (reply),
        .miso_o    (spi_miso),
        .frame_o   (frame),
        .done_o    (frame_done),
        .cs_idle_o (cs_idle)
    );

    att_cmd_exec u_exec (
        .clk       (clk),
        .rst       (rst),
        .apply_i   (frame_done),
        .frame_i   (frame),
        .rx_pair_o (rx_pair),
        .tx_pair_o (tx_pair),
        .rx_lo_o   (rx_lo_att),
        .tx_lo_o   (tx_lo_att),
        .scratch_o (scratch),
        .band_o    (band)
    );

    // Reply built from the partially received frame: each field it depends
    // on has arrived before the first reply bit that uses it is shifted out.
    assign kind   = frame_kind_e'(frame[23:22]);
    assign reg_rd = (kind == K_REG) && frame[16];

    always_comb begin
        if (frame[23:17] == ADDR_SCR)      rd_data = scratch;
        else if (frame[23:17] == ADDR_BND) rd_data = {14'd0, band};
        else                               rd_data = '0;
    end

    always_comb begin
        if (reg_rd)
            reply = {8'd0, rd_data};
        else if (kind == K_LO)
            reply = {11'd0, 1'b0, rx_lo_att, 1'b0, 1'b0, tx_lo_att};
        else if (kind == K_TXG)
            reply = {11'd0, tx_pair.first, 1'b0, tx_pair.second};
        else
            reply = {11'd0, rx_pair.first, 1'b0, rx_pair.second};
    end

    assign rx_att_a = rx_pair.first;
    assign rx_att_b = rx_pair.second;
    assign tx_att_a = tx_pair.first;
    assign tx_att_b = tx_pair.second;

endmodule

// File: rtl/att_ctrl_checker.sv
module att_ctrl_checker (
    input logic       clk,
    input logic       rst,
    input logic       apply,
    input logic       cs_idle,
    input logic       miso,
    input logic [5:0] rx_a,
    input logic [5:0] rx_b,
    input logic [5:0] tx_a,
    input logic [5:0] tx_b,
    input logic [4:0] rx_lo,
    input logic [4:0] tx_lo
);
    AST_RESET_MAX_ATT: assert property (@(posedge clk)
        rst |=> (rx_a == 6'h3F && rx_b == 6'h3F && tx_a == 6'h3F && tx_b == 6'h3F
                 && rx_lo == 5'd30 && tx_lo == 5'd30 && !miso)); // R2

    AST_LO_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (rx_lo <= 5'd30) && (tx_lo <= 5'd30)); // R8

    AST_HOLD_WITHOUT_FRAME: assert property (@(posedge clk) disable iff (rst)
        !apply |=> ($stable(rx_a) && $stable(rx_b) && $stable(tx_a) && $stable(tx_b)
                    && $stable(rx_lo) && $stable(tx_lo))); // R10

    AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        cs_idle |=> !miso); // R11

endmodule

bind spi_atten_ctrl att_ctrl_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .apply   (frame_done),
    .cs_idle (cs_idle),
    .miso    (spi_miso),
    .rx_a    (rx_att_a),
    .rx_b    (rx_att_b),
    .tx_a    (tx_att_a),
    .tx_b    (tx_att_b),
    .rx_lo   (rx_lo_att),
    .tx_lo   (tx_lo_att)
);

// File: tb/sim_spi_atten_ctrl.sv
`timescale 1ns/1ps
module sim_spi_atten_ctrl;

    localparam int H = 8;       // clk cycles per SCLK half period
    localparam int NVEC = 22;
    localparam logic [23:0] VEC [NVEC] = '{
        24'h4A2040, 24'h0ABEEF, 24'h0B0000, 24'h0C0003, 24'h472040, 24'h802040,
        24'h0C0000, 24'hA12000, 24'h7D2040, 24'h7C2040, 24'hC52040, 24'hDF2040,
        24'hDE2000, 24'hC00040, 24'hBB0040, 24'h0D0000, 24'h041234, 24'h050000,
        24'h0C0002, 24'h8F0040, 24'h0D0000, 24'h0B0000
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic miso;
    logic [5:0] rx_a, rx_b, tx_a, tx_b;
    logic [4:0] rx_lo, tx_lo;

    always #2 clk = ~clk;

    spi_atten_ctrl u0 (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
        .spi_miso(miso), .rx_att_a(rx_a), .rx_att_b(rx_b), .tx_att_a(tx_a),
        .tx_att_b(tx_b), .rx_lo_att(rx_lo), .tx_lo_att(tx_lo)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    int m_rxa, m_rxb, m_txa, m_txb, m_rxlo, m_txlo, m_scr, m_band;

    task automatic m_reset();
        m_rxa = 63; m_rxb = 63; m_txa = 63; m_txb = 63;
        m_rxlo = 30; m_txlo = 30; m_scr = 0; m_band = 0;
    endtask

    function automatic logic [47:0] m_outs();
        return {14'd0, 6'(m_rxa), 6'(m_rxb), 6'(m_txa), 6'(m_txb), 5'(m_rxlo), 5'(m_txlo)};
    endfunction

    function automatic logic [47:0] dut_outs();
        return {14'd0, rx_a, rx_b, tx_a, tx_b, rx_lo, tx_lo};
    endfunction

    function automatic int m_regread(int addr);
        if (addr == 5) return m_scr;
        if (addr == 6) return m_band;
        return 0;
    endfunction

    function automatic logic [23:0] m_reply(logic [23:0] f);
        int k = int'(f[23:22]);
        if (k == 0 && f[16]) return {8'd0, 16'(m_regread(int'(f[23:17])))};
        if (k == 3) return {11'd0, 6'(m_rxlo), 1'b0, 6'(m_txlo)};
        if (k == 2) return {11'd0, 6'(m_txa), 1'b0, 6'(m_txb)};
        return {11'd0, 6'(m_rxa), 1'b0, 6'(m_rxb)};
    endfunction

    task automatic m_apply(logic [23:0] f);
        int k = int'(f[23:22]);
        int v = int'(f[21:16]);
        int t, lo, hi, fa, fb;
        if (k == 0) begin
            if (!f[16]) begin
                if (f[23:17] == 7'd5) m_scr = int'(f[15:0]);
                else if (f[23:17] == 7'd6) m_band = int'(f[1:0]);
            end
        end else if (k == 3) begin
            if (v <= 30) begin
                if (f[13]) m_rxlo = v;
                if (f[6])  m_txlo = v;
            end
        end else if (v <= 60) begin
            t = 60 - v; lo = t / 2; hi = t - lo;
            if (k == 1) begin
                if (m_band[0]) begin fa = lo; fb = hi; end
                else           begin fa = hi; fb = lo; end
                if (f[13]) m_rxa = fa;
                if (f[6])  m_rxb = fb;
            end else begin
                if (m_band[1]) begin fa = 0; fb = t; end
                else           begin fa = t; fb = 0; end
                if (f[13]) m_txa = fa;
                if (f[6])  m_txb = fb;
            end
        end
    endtask

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [23:0] f, input int nbits, output logic [23:0] r);
        r = '0;
        @(negedge clk) csn = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 24) ? f[23-i] : 1'b0;
            repeat (H) @(negedge clk);
            if (i < 24) r[23-i] = miso;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (H) @(negedge clk);
        csn = 1'b1;
        repeat (2*H) @(negedge clk);
    endtask

    function automatic string tag_of(logic [23:0] f);
        case (f[23:22])
            2'd0:    return "R4";
            2'd3:    return "R8";
            default: return "R5";
        endcase
    endfunction

    task automatic run_vec(input logic [23:0] f, input string tag);
        logic [23:0] r;
        logic [23:0] er;
        er = m_reply(f);
        xfer(f, 24, r);
        check("R9 reply", {24'd0, r}, {24'd0, er});
        m_apply(f);
        check(tag, dut_outs(), m_outs());
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        m_reset();
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [23:0] r;
        logic [47:0] snap;
        m_reset();
        repeat (3) @(negedge clk);
        // R2: outputs during reset
        check("R2 reset outputs", dut_outs(), m_outs());
        check("R2 miso in reset", {47'd0, miso}, 48'd0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R11 miso idle", {47'd0, miso}, 48'd0);

        // R1/R3/R4/R5/R6/R7/R8/R9: vector table
        for (int i = 0; i < NVEC; i++) run_vec(VEC[i], tag_of(VEC[i]));

        // R3: kind field 1 with no enables changes nothing
        run_vec(24'h400000, "R3 kind-1 frame without enables");
        // R3: kind 3 frame addresses the LO pair, not the gain pairs
        run_vec(24'hC72040, "R3 kind-3 frame updates LO only");

        // R1: short and long frames are discarded
        snap = dut_outs();
        xfer(24'h4A2040, 23, r);
        check("R1 23-bit frame discarded", dut_outs(), snap);
        xfer(24'h802040, 25, r);
        check("R1 25-bit frame discarded", dut_outs(), snap);
        run_vec(24'h0B0000, "R1 scratch intact after bad frames");

        // R6: only the second attenuator enabled
        run_vec(24'h550040, "R6 second-only update");
        // R7: index 63 ignored
        snap = dut_outs();
        xfer(24'h7F2040, 24, r);
        check("R7 index 63 ignored", dut_outs(), snap);
        // R10: register write leaves attenuators unchanged
        xfer(24'h0A1357, 24, r);
        m_apply(24'h0A1357);
        check("R10 register write keeps outputs", dut_outs(), snap);
        check("R11 miso low after frame", {47'd0, miso}, 48'd0);

        // R2: reset in mid run restores defaults and clears registers
        do_reset();
        check("R2 outputs after reset", dut_outs(), m_outs());
        run_vec(24'h0B0000, "R2 scratch cleared");
        run_vec(24'h0D0000, "R2 band cleared");

        finished = 1;
        summary();
        $finish;
    end

endmodule